// File: doc/BRIEF.md
# Write-Through Store Path with Posted Write Queue

This block sits between a processor's store port, a small direct-mapped data cache and a slow memory. Every store the processor presents is examined against the cache tags. When the addressed line is resident, a one-cycle update strobe with the word index, data and byte enables goes to the cache data array. Whether it hits or misses, the store is always posted into a small first-in first-out queue. A store that misses never claims a line and never fetches the rest of the block. The line install port is the minimal stand-in for the read-miss path: it marks a line resident under a new tag.

The memory side empties the queue on its own schedule through a valid/ready write port, one entry per handshake, in the order the stores were accepted. When the memory cannot keep pace with the store rate the queue fills up, and the processor is held off through its ready signal until a slot frees. A store and a drain in the same cycle on a full queue both proceed. The empty flag tells later reads when every posted write has reached memory.

Top module: `wt_store_path`

## Requirements
- R1: After reset the queue is empty (`buf_empty`=1, `mem_valid`=0), `st_ready` is 1 and no cache line is resident, so no store produces `cupd_en`.
- R2: The byte address splits into byte offset [1:0], word [3:2], index [6:4] and tag [15:7]. An accepted store whose index holds a resident line with an equal tag raises `cupd_en` in the same cycle, with `cupd_index`=addr[6:4], `cupd_word`=addr[3:2] and the store's data and byte enables.
- R3: An accepted store that misses raises no `cupd_en` and installs no line, so a repeat store to the same address also misses.
- R4: Every accepted store is queued, and it leaves on `mem_addr`, `mem_data` and `mem_be` unchanged, in acceptance order.
- R5: `mem_valid` is 1 exactly when the queue holds an entry. An entry is removed only on a cycle with `mem_valid` and `mem_ready` both high, and the outputs hold steady while `mem_ready` is low.
- R6: The queue holds 4 entries. With 4 pending and `mem_ready` low, `st_ready` is 0 and an offered store is not taken.
- R7: With 4 pending and `mem_ready` high, `st_ready` is 1. The head drains and the new store is queued in the same cycle, with nothing lost.
- R8: `buf_empty` is 1 exactly when no posted write is pending.
- R9: A cycle with `fill_valid` high makes the line at index `fill_line`[2:0] resident with tag `fill_line`[11:3], where `fill_line` is addr[15:4]. This replaces any earlier tag at that index.
- R10: A store offered while `st_ready` is 0 neither updates the cache nor enters the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 16 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| fill_valid | input | 1 | Install a line (read-miss path) |
| fill_line | input | 12 | Line address (tag and index) to install |
| cupd_en | output | 1 | Cache data write strobe on a store hit |
| cupd_index | output | 3 | Line index to update |
| cupd_word | output | 2 | Word within the line |
| cupd_data | output | 32 | Data for the cache word |
| cupd_be | output | 4 | Byte enables for the cache word |
| mem_valid | output | 1 | A posted write is offered to memory |
| mem_ready | input | 1 | Memory takes the offered write |
| mem_addr | output | 16 | Address of the head write |
| mem_data | output | 32 | Data of the head write |
| mem_be | output | 4 | Byte enables of the head write |
| buf_empty | output | 1 | No posted write pending |

## Verification
Directed runs cover these cases:
- a cold cache;
- an install followed by a hit;
- a repeated miss to one address, which shows that a miss does not allocate;
- an install of a second tag at the same index, which shows eviction;
- stores held against a stalled memory until the queue saturates, then one store offered while full with the memory stalled and one with it ready, which separates the two full-queue rules.

A long random phase mixes bursty stores over a few tags and indices with random memory back-pressure and occasional installs. It checks the hit/miss decision, the drain order and the handshake against a reference queue and tag table kept in the bench.

// File: rtl/wt_store_pkg.sv
package wt_store_pkg;
  localparam int unsigned WT_ADDR_W     = 16;
  localparam int unsigned WT_DATA_W     = 32;
  localparam int unsigned WT_LINES      = 8;
  localparam int unsigned WT_LINE_BYTES = 16;
  localparam int unsigned WT_DEPTH      = 4;

  // width of an index into n items, at least one bit
  function automatic int unsigned wt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wt_tag_store.sv
module wt_tag_store
  import wt_store_pkg::*;
#(
  parameter int unsigned LINES = WT_LINES,
  parameter int unsigned TAG_W = 9,
  localparam int unsigned IDX_W = wt_bits(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (fill_en && (fill_idx == IDX_W'(g))) tag_q[g] <= fill_tag;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];

  // a store (hit or miss) never changes residency; only an install does
  assert_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $stable(valid_q));
  assert_fill_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] == 1'b1));
endmodule

// File: rtl/wt_store_fifo.sv
module wt_store_fifo
  import wt_store_pkg::*;
#(
  parameter int unsigned DEPTH = WT_DEPTH,
  parameter int unsigned WIDTH = 52,
  localparam int unsigned PTR_W = wt_bits(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             full,
  output logic             empty,
  output logic [WIDTH-1:0] head
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [WIDTH-1:0] slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);
  assign head  = slot_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    case ({push, pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr_q == PTR_W'(s))) slot_q[s] <= push_data;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count_q == $past(count_q) + CNT_W'(1)));
  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full) |=> full);
endmodule

// File: rtl/wt_store_path.sv
module wt_store_path
  import wt_store_pkg::*;
#(
  parameter int unsigned ADDR_W     = WT_ADDR_W,
  parameter int unsigned DATA_W     = WT_DATA_W,
  parameter int unsigned LINES      = WT_LINES,
  parameter int unsigned LINE_BYTES = WT_LINE_BYTES,
  parameter int unsigned DEPTH      = WT_DEPTH,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned OFS_W  = $clog2(LINE_BYTES),
  localparam int unsigned BYTE_W = $clog2(BE_W),
  localparam int unsigned WORD_W = OFS_W - BYTE_W,
  localparam int unsigned IDX_W  = wt_bits(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFS_W - IDX_W,
  localparam int unsigned LINE_W = ADDR_W - OFS_W,
  localparam int unsigned ENT_W  = ADDR_W + DATA_W + BE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  output logic              cupd_en,
  output logic [IDX_W-1:0]  cupd_index,
  output logic [WORD_W-1:0] cupd_word,
  output logic [DATA_W-1:0] cupd_data,
  output logic [BE_W-1:0]   cupd_be,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  output logic              buf_empty
);
  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] st_idx;
  logic [TAG_W-1:0] st_tag;
  logic             lk_valid;
  logic [TAG_W-1:0] lk_tag;
  logic             st_hit;
  logic             st_take;
  logic             q_full;
  logic             q_empty;
  logic             q_pop;
  logic [ENT_W-1:0] q_head;

  assign st_idx = st_addr[OFS_W +: IDX_W];
  assign st_tag = st_addr[ADDR_W-1 -: TAG_W];

  wt_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fill_en  (fill_valid),
    .fill_idx (fill_line[IDX_W-1:0]),
    .fill_tag (fill_line[LINE_W-1 -: TAG_W]),
    .lk_idx   (st_idx),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag)
  );

  assign st_hit   = lk_valid && (lk_tag == st_tag);
  // a full queue still takes a store when its head leaves in the same cycle
  assign st_ready = !q_full || mem_ready;
  assign st_take  = st_valid && st_ready;
  assign q_pop    = !q_empty && mem_ready;

  assign cupd_en    = st_take && st_hit;
  assign cupd_index = st_idx;
  assign cupd_word  = st_addr[BYTE_W +: WORD_W];
  assign cupd_data  = st_data;
  assign cupd_be    = st_be;

  wt_store_fifo #(
    .DEPTH (DEPTH),
    .WIDTH (ENT_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (st_take),
    .push_data ({st_addr, st_data, st_be}),
    .pop       (q_pop),
    .full      (q_full),
    .empty     (q_empty),
    .head      (q_head)
  );

  assign mem_valid = !q_empty;
  assign buf_empty = q_empty;
  assign {mem_addr, mem_data, mem_be} = q_head;

  assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
  assert_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!st_ready) |-> (mem_valid && !buf_empty));
  assert_empty_after_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (buf_empty && !st_valid) |=> buf_empty);
endmodule

// File: tb/test_wt_store_path.sv
module test_wt_store_path;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_valid, st_ready;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic [3:0]  st_be;
  logic        fill_valid;
  logic [11:0] fill_line;
  logic        cupd_en;
  logic [2:0]  cupd_index;
  logic [1:0]  cupd_word;
  logic [31:0] cupd_data;
  logic [3:0]  cupd_be;
  logic        mem_valid, mem_ready;
  logic [15:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;
  logic        buf_empty;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model
  logic [15:0] qa [$];
  logic [31:0] qd [$];
  logic [3:0]  qb [$];
  bit          mv [8];
  logic [8:0]  mt [8];

  always #4 clk = ~clk;

  wt_store_path i_wt_store_path (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .cupd_en(cupd_en), .cupd_index(cupd_index), .cupd_word(cupd_word),
    .cupd_data(cupd_data), .cupd_be(cupd_be),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .buf_empty(buf_empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int tag, input int idx, input int word);
    return {tag[8:0], idx[2:0], word[1:0], 2'b00};
  endfunction

  function automatic bit model_hit(input logic [15:0] a);
    return mv[a[6:4]] && (mt[a[6:4]] == a[15:7]);
  endfunction

  // one clock: drive at the falling edge, check, then advance the model
  task automatic step(input bit sv, input logic [15:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit mr, input bit fv,
                      input logic [11:0] fl);
    bit exp_ready, take, hit;
    string rq;
    @(negedge clk);
    st_valid = sv; st_addr = a; st_data = d; st_be = be;
    mem_ready = mr; fill_valid = fv; fill_line = fl;
    #1;
    exp_ready = (qa.size() < DEPTH) || mr;
    rq = (qa.size() < DEPTH) ? "R6" : (mr ? "R7" : "R6");
    chk(st_ready == exp_ready, rq, st_ready, exp_ready);
    take = sv && exp_ready;
    hit  = model_hit(a);
    rq = (sv && !exp_ready) ? "R10" : (hit ? "R2" : "R3");
    chk(cupd_en == (take && hit), rq, cupd_en, take && hit);
    if (take && hit) begin
      chk({cupd_index, cupd_word} == {a[6:4], a[3:2]}, "R2", {cupd_index, cupd_word}, {a[6:4], a[3:2]});
      chk({cupd_data, cupd_be} == {d, be}, "R2", {cupd_data, cupd_be}, {d, be});
    end
    chk(mem_valid == (qa.size() != 0), "R5", mem_valid, qa.size() != 0);
    chk(buf_empty == (qa.size() == 0), "R8", buf_empty, qa.size() == 0);
    if (qa.size() != 0)
      chk({mem_addr, mem_data, mem_be} == {qa[0], qd[0], qb[0]}, "R4",
          {mem_addr, mem_data, mem_be}, {qa[0], qd[0], qb[0]});
    if (qa.size() != 0 && mr) begin
      void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
    end
    if (take) begin
      qa.push_back(a); qd.push_back(d); qb.push_back(be);
    end
    if (fv) begin
      mv[fl[2:0]] = 1'b1;
      mt[fl[2:0]] = fl[11:3];
    end
  endtask

  task automatic store(input logic [15:0] a, input bit mr);
    step(1'b1, a, $urandom, 4'($urandom), mr, 1'b0, '0);
  endtask

  task automatic idle(input bit mr);
    step(1'b0, '0, '0, '0, mr, 1'b0, '0);
  endtask

  task automatic fill(input logic [15:0] a);
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, a[15:4]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] a_x, a_y;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    rst_n = 1'b0; st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    mem_ready = 0; fill_valid = 0; fill_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(buf_empty == 1'b1, "R1", buf_empty, 1);
    chk(mem_valid == 1'b0, "R1", mem_valid, 0);
    chk(st_ready == 1'b1, "R1", st_ready, 1);
    store(mk_addr(0, 0, 0), 1'b0);   // R1: cold cache, no hit
    idle(1'b1);

    a_x = mk_addr(2, 1, 3);
    a_y = mk_addr(5, 1, 0);
    // R3: miss does not allocate, repeat still misses
    store(a_x, 1'b0);
    store(a_x, 1'b0);
    idle(1'b1); idle(1'b1);
    // R9 then R2: install and hit
    fill(a_x);
    store(a_x, 1'b0);
    // R9: other tag at same index evicts
    fill(a_y);
    store(a_x, 1'b0);
    store(a_y, 1'b0);
    repeat (3) idle(1'b1);

    // R6 / R10 / R7: saturation with stalled memory
    for (int i = 0; i < DEPTH; i++) store(mk_addr(1, i, i), 1'b0);
    store(mk_addr(3, 7, 1), 1'b0);     // refused (R10)
    store(mk_addr(3, 7, 1), 1'b0);     // refused again
    store(mk_addr(4, 6, 2), 1'b1);     // full, drain and store together (R7)
    store(mk_addr(4, 6, 3), 1'b0);     // still full, refused (R6)
    repeat (DEPTH + 1) idle(1'b1);     // drain all in order (R4, R8)
    chk(buf_empty == 1'b1, "R8", buf_empty, 1);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [15:0] ra;
      bit sv, mr, fv;
      ra = mk_addr($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3));
      sv = ($urandom_range(0, 99) < 70);
      mr = ($urandom_range(0, 99) < ((c / 500) % 2 == 0 ? 30 : 80));
      fv = ($urandom_range(0, 99) < 8);
      step(sv, ra, $urandom, 4'($urandom), mr, fv,
           {9'($urandom_range(0, 3)), 3'($urandom_range(0, 7))});
    end
    repeat (DEPTH + 2) idle(1'b1);
    chk(buf_empty == 1'b1, "R8", buf_empty, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule